// File: doc/BRIEF.md
# Three-Stage Pipelined Feistel Round

This block computes a single round of a 64-bit Feistel cipher of the DES family. It is cut into three register stages, so a fresh block may be presented on every clock edge and its result leaves the block exactly three clocks later. The round takes the 32-bit right half and widens it to 48 bits. It mixes that value with a 48-bit round subkey, pushes it through eight 6-to-4 bit substitution tables and reorders the 32-bit result with a fixed bit permutation. It then folds the permuted word into the left half and swaps the halves.

A full cipher is built by chaining sixteen copies, each fed with its own subkey. That chain has a latency of 48 clocks and a throughput of one block per clock. The block has no stall and no handshake. A valid flag travels with each block and marks which output words carry results.

Bit convention used throughout: within a 32-bit half, cipher bit 1 is the most significant bit (bit 31) and cipher bit 32 is bit 0. The same holds for the 48-bit values, where cipher bit 1 is bit 47.

Top module: `feistel_round_pipe`

## Requirements
- R1: `out_valid` equals the value `in_valid` had three rising edges earlier. Every valid input gives exactly one valid output, in arrival order.
- R2: While `rst` is high, and on the first cycle after it falls, `out_valid` is 0. A block presented during reset never produces a valid output.
- R3: The upper half `out_state[63:32]` of a valid result equals the right half `in_state[31:0]` of the matching input.
- R4: The expansion builds eight 6-bit groups. Group g (g = 0..7, group 0 in bits 47:42) holds cipher bits 4g, 4g+1, ..., 4g+5 of the right half, with bit number 0 read as bit 32 and 33 read as 1. The first and last bit of each group are therefore shared with the neighbouring groups, and the two end groups wrap around.
- R5: The expanded value is XORed with `in_key` before substitution. With a zero right half, the table inputs are exactly the subkey bits.
- R6: Group g of the mixed value indexes table g. The row is {first bit, last bit} of the group and the column is its middle four bits. The 4-bit result of table g fills bits 31-4g down to 28-4g of the substitution word. The tables are the standard DES S1..S8, and an all-zero mixed value yields the substitution word 32'hEFA72C4D.
- R7: The substitution word is permuted so that output cipher bit j (1..32) takes the input bit with 0-based cipher index given, for j = 1..32, by 15 6 19 20 28 11 27 16 0 14 22 25 4 17 30 9 1 7 23 13 31 26 2 8 18 12 29 5 21 10 3 24.
- R8: The lower half `out_state[31:0]` of a valid result equals the input's left half `in_state[63:32]` XORed with the permuted word.
- R9: Blocks presented on consecutive cycles each give the correct result on consecutive cycles, with no bubble.
- R10: A cycle with `in_valid` low gives a cycle with `out_valid` low three clocks later, whatever the data and key inputs hold in that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset, clears all valid flags |
| in_valid | input | 1 | Marks the current input block as a real block |
| in_state | input | 64 | Round input, left half in [63:32], right half in [31:0] |
| in_key | input | 48 | Round subkey for the block in the same cycle |
| out_valid | output | 1 | Marks `out_state` as a real result |
| out_state | output | 64 | Round output, new left half in [63:32], new right half in [31:0] |

## Verification
The assertions check on every cycle the three-clock alignment of the valid flag with its input and the silence after reset. They also check that the right half reappears as the new left half, that a zero right half passes the subkey straight to the tables, and that an all-zero table input gives the known substitution word. Only the bench scenarios can show that the substitution and permutation are correct for arbitrary values. Those scenarios are a sweep of all 64 entries of every table, single-bit right halves that probe the shared and wrapped expansion bits, back-to-back streaming and gapped traffic. A reset in the middle of a stream must also drop the blocks still in flight.

// File: rtl/fr_pkg.sv
package fr_pkg;
  localparam int HALF_W    = 32;
  localparam int BLOCK_W   = 2 * HALF_W;
  localparam int SUBKEY_W  = 48;
  localparam int N_BOX     = 8;
  localparam int BOX_IN_W  = SUBKEY_W / N_BOX;
  localparam int BOX_OUT_W = HALF_W / N_BOX;
  localparam int EXP_STEP  = HALF_W / N_BOX;
  localparam int DEPTH     = 3;

  // 0-based cipher index feeding output cipher bit j+1
  localparam int PERM_SRC [HALF_W] = '{
    15, 6, 19, 20, 28, 11, 27, 16,
    0, 14, 22, 25, 4, 17, 30, 9,
    1, 7, 23, 13, 31, 26, 2, 8,
    18, 12, 29, 5, 21, 10, 3, 24
  };

  // Widen a half: each group is a 6-bit window over the half with one
  // wrap bit on each end.
  function automatic logic [SUBKEY_W-1:0] expand_half(input logic [HALF_W-1:0] r);
    logic [HALF_W+1:0]   ring;
    logic [SUBKEY_W-1:0] e;
    ring = {r[0], r, r[HALF_W-1]};
    e = '0;
    for (int g = 0; g < N_BOX; g++) begin
      e[SUBKEY_W-1-BOX_IN_W*g -: BOX_IN_W] = ring[HALF_W+1-EXP_STEP*g -: BOX_IN_W];
    end
    return e;
  endfunction

  function automatic logic [HALF_W-1:0] permute_half(input logic [HALF_W-1:0] s);
    logic [HALF_W-1:0] p;
    p = '0;
    for (int j = 0; j < HALF_W; j++) begin
      p[HALF_W-1-j] = s[HALF_W-1-PERM_SRC[j]];
    end
    return p;
  endfunction
endpackage

// File: rtl/fr_sbox.sv
module fr_sbox #(
  parameter int BOX_ID = 0
) (
  input  logic [fr_pkg::BOX_IN_W-1:0]  sel,
  output logic [fr_pkg::BOX_OUT_W-1:0] val
);
  localparam logic [2:0] BID = 3'(BOX_ID);

  logic [1:0]  row;
  logic [3:0]  col;
  logic [63:0] line;
  logic [5:0]  msb_idx;

  assign row     = {sel[5], sel[0]};
  assign col     = sel[4:1];
  assign msb_idx = 6'd63 - {col, 2'b00};

  always_comb begin
    line = '0;
    case ({BID, row})
      5'd0:  line = 64'hE4D12FB83A6C5907;
      5'd1:  line = 64'h0F74E2D1A6CB9538;
      5'd2:  line = 64'h41E8D62BFC973A50;
      5'd3:  line = 64'hFC8249175B3EA06D;
      5'd4:  line = 64'hF18E6B34972DC05A;
      5'd5:  line = 64'h3D47F28EC01A69B5;
      5'd6:  line = 64'h0E7BA4D158C6932F;
      5'd7:  line = 64'hD8A13F42B67C05E9;
      5'd8:  line = 64'hA09E63F51DC7B428;
      5'd9:  line = 64'hD70934A628E5CBF1;
      5'd10: line = 64'hD6498F30B12C5AE7;
      5'd11: line = 64'h1AD069874FE3B52C;
      5'd12: line = 64'h7DE3069A1285BC4F;
      5'd13: line = 64'hD8B56F03472C1AE9;
      5'd14: line = 64'hA690CB7DF13E5284;
      5'd15: line = 64'h3F06A1D8945BC72E;
      5'd16: line = 64'h2C417AB6853FD0E9;
      5'd17: line = 64'hEB2C47D150FA3986;
      5'd18: line = 64'h421BAD78F9C5630E;
      5'd19: line = 64'hB8C71E2D6F09A453;
      5'd20: line = 64'hC1AF92680D34E75B;
      5'd21: line = 64'hAF427C9561DE0B38;
      5'd22: line = 64'h9EF528C3704A1D6B;
      5'd23: line = 64'h432C95FABE17608D;
      5'd24: line = 64'h4B2EF08D3C975A61;
      5'd25: line = 64'hD0B7491AE35C2F86;
      5'd26: line = 64'h14BDC37EAF680592;
      5'd27: line = 64'h6BD814A7950FE23C;
      5'd28: line = 64'hD2846FB1A93E50C7;
      5'd29: line = 64'h1FD8A374C56B0E92;
      5'd30: line = 64'h7B419CE206ADF358;
      default: line = 64'h21E74A8DFC90356B;
    endcase
  end

  assign val = line[msb_idx -: 4];
endmodule

// File: rtl/fr_stage_mix.sv
module fr_stage_mix
  import fr_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  input  logic [BLOCK_W-1:0]  in_state,
  input  logic [SUBKEY_W-1:0] in_key,
  output logic                v1,
  output logic [SUBKEY_W-1:0] mix1,
  output logic [HALF_W-1:0]   left1,
  output logic [HALF_W-1:0]   right1
);
  always_ff @(posedge clk) begin
    if (rst) v1 <= 1'b0;
    else     v1 <= in_valid;
  end

  always_ff @(posedge clk) begin
    mix1   <= expand_half(in_state[HALF_W-1:0]) ^ in_key;
    left1  <= in_state[BLOCK_W-1:HALF_W];
    right1 <= in_state[HALF_W-1:0];
  end

  AST_ZERO_RIGHT_KEY_PASS: assert property (@(posedge clk) disable iff (rst)
    (in_state[HALF_W-1:0] == '0) |=> (mix1 == $past(in_key))); // R5
endmodule

// File: rtl/fr_stage_sub.sv
module fr_stage_sub
  import fr_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                v1,
  input  logic [SUBKEY_W-1:0] mix1,
  input  logic [HALF_W-1:0]   left1,
  input  logic [HALF_W-1:0]   right1,
  output logic                v2,
  output logic [HALF_W-1:0]   sub2,
  output logic [HALF_W-1:0]   left2,
  output logic [HALF_W-1:0]   right2
);
  logic [HALF_W-1:0] sub_c;

  for (genvar g = 0; g < N_BOX; g++) begin : g_box
    fr_sbox #(.BOX_ID(g)) box_i (
      .sel (mix1[SUBKEY_W-1-BOX_IN_W*g -: BOX_IN_W]),
      .val (sub_c[HALF_W-1-BOX_OUT_W*g -: BOX_OUT_W])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) v2 <= 1'b0;
    else     v2 <= v1;
  end

  always_ff @(posedge clk) begin
    sub2   <= sub_c;
    left2  <= left1;
    right2 <= right1;
  end

  AST_ZERO_MIX_WORD: assert property (@(posedge clk) disable iff (rst)
    (mix1 == '0) |=> (sub2 == 32'hEFA72C4D)); // R6
endmodule

// File: rtl/fr_stage_out.sv
module fr_stage_out
  import fr_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               v2,
  input  logic [HALF_W-1:0]  sub2,
  input  logic [HALF_W-1:0]  left2,
  input  logic [HALF_W-1:0]  right2,
  output logic               out_valid,
  output logic [BLOCK_W-1:0] out_state
);
  always_ff @(posedge clk) begin
    if (rst) out_valid <= 1'b0;
    else     out_valid <= v2;
  end

  always_ff @(posedge clk) begin
    out_state <= {right2, left2 ^ permute_half(sub2)};
  end

  AST_QUIET_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !out_valid); // R2
endmodule

// File: rtl/feistel_round_pipe.sv
module feistel_round_pipe
  import fr_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  input  logic [BLOCK_W-1:0]  in_state,
  input  logic [SUBKEY_W-1:0] in_key,
  output logic                out_valid,
  output logic [BLOCK_W-1:0]  out_state
);
  logic                v1, v2;
  logic [SUBKEY_W-1:0] mix1;
  logic [HALF_W-1:0]   left1, right1, sub2, left2, right2;

  fr_stage_mix mix_i (
    .clk (clk), .rst (rst), .in_valid (in_valid), .in_state (in_state),
    .in_key (in_key), .v1 (v1), .mix1 (mix1), .left1 (left1), .right1 (right1)
  );

  fr_stage_sub sub_i (
    .clk (clk), .rst (rst), .v1 (v1), .mix1 (mix1), .left1 (left1),
    .right1 (right1), .v2 (v2), .sub2 (sub2), .left2 (left2), .right2 (right2)
  );

  fr_stage_out out_i (
    .clk (clk), .rst (rst), .v2 (v2), .sub2 (sub2), .left2 (left2),
    .right2 (right2), .out_valid (out_valid), .out_state (out_state)
  );

  // Cycles since reset, saturating at the pipeline depth; guards the
  // three-deep history used by the checks below.
  logic [1:0] age;
  always_ff @(posedge clk) begin
    if (rst)                  age <= '0;
    else if (age != 2'(DEPTH)) age <= age + 2'd1;
  end

  AST_VALID_DELAY: assert property (@(posedge clk) disable iff (rst)
    (age == 2'(DEPTH)) |-> (out_valid == $past(in_valid, 3))); // R1
  AST_RIGHT_BECOMES_LEFT: assert property (@(posedge clk) disable iff (rst)
    (age == 2'(DEPTH) && out_valid) |->
      (out_state[BLOCK_W-1:HALF_W] == $past(in_state[HALF_W-1:0], 3))); // R3
endmodule

// File: tb/feistel_round_pipe_tb_top.sv
`timescale 1ns/1ps
module feistel_round_pipe_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [63:0] in_state = '0;
  logic [47:0] in_key = '0;
  logic        out_valid;
  logic [63:0] out_state;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  feistel_round_pipe dut_i (
    .clk (clk), .rst (rst), .in_valid (in_valid), .in_state (in_state),
    .in_key (in_key), .out_valid (out_valid), .out_state (out_state)
  );

  // Tables in row-major nibble strings, box 1 first
  localparam logic [255:0] SB [8] = '{
    256'hE4D12FB83A6C5907_0F74E2D1A6CB9538_41E8D62BFC973A50_FC8249175B3EA06D,
    256'hF18E6B34972DC05A_3D47F28EC01A69B5_0E7BA4D158C6932F_D8A13F42B67C05E9,
    256'hA09E63F51DC7B428_D70934A628E5CBF1_D6498F30B12C5AE7_1AD069874FE3B52C,
    256'h7DE3069A1285BC4F_D8B56F03472C1AE9_A690CB7DF13E5284_3F06A1D8945BC72E,
    256'h2C417AB6853FD0E9_EB2C47D150FA3986_421BAD78F9C5630E_B8C71E2D6F09A453,
    256'hC1AF92680D34E75B_AF427C9561DE0B38_9EF528C3704A1D6B_432C95FABE17608D,
    256'h4B2EF08D3C975A61_D0B7491AE35C2F86_14BDC37EAF680592_6BD814A7950FE23C,
    256'hD2846FB1A93E50C7_1FD8A374C56B0E92_7B419CE206ADF358_21E74A8DFC90356B
  };
  localparam int PS [32] = '{15,6,19,20,28,11,27,16,0,14,22,25,4,17,30,9,
                             1,7,23,13,31,26,2,8,18,12,29,5,21,10,3,24};

  // Behavioural round, cipher bit k of a half is vector bit (width - k)
  function automatic logic [63:0] ref_round(input logic [63:0] st, input logic [47:0] k);
    logic [31:0] l, r, s, p;
    logic [47:0] x;
    l = st[63:32];
    r = st[31:0];
    for (int j = 1; j <= 48; j++) begin
      int g, q, src;
      g = (j - 1) / 6;
      q = (j - 1) % 6;
      src = ((4 * g + q + 31) % 32) + 1;
      x[48 - j] = r[32 - src] ^ k[48 - j];
    end
    for (int b = 0; b < 8; b++) begin
      logic [5:0] grp;
      int row, col, ent;
      grp = x[47 - 6 * b -: 6];
      row = grp[5] * 2 + grp[0];
      col = grp[4:1];
      ent = row * 16 + col;
      s[31 - 4 * b -: 4] = SB[b][255 - 4 * ent -: 4];
    end
    for (int j = 1; j <= 32; j++) p[32 - j] = s[31 - PS[j - 1]];
    return {r, l ^ p};
  endfunction

  // Three-entry history of driven blocks: [0] newest
  logic        h_v [3];
  logic [63:0] h_s [3];
  string       h_t [3];

  task automatic clear_hist();
    for (int i = 0; i < 3; i++) begin
      h_v[i] = 1'b0;
      h_s[i] = '0;
      h_t[i] = "R2";
    end
  endtask

  task automatic fail(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_bad++;
    $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
  endtask

  // One negedge: check what left the pipe, then drive the next block
  task automatic step(input logic v, input logic [63:0] st, input logic [47:0] k, input string tag);
    @(negedge clk);
    n_chk++;
    if (out_valid !== h_v[2]) fail({h_t[2], "/R1"}, "out_valid", 64'(out_valid), 64'(h_v[2]));
    if (h_v[2]) begin
      n_chk++;
      if (out_state !== h_s[2]) fail(h_t[2], "out_state", out_state, h_s[2]);
    end
    for (int i = 2; i > 0; i--) begin
      h_v[i] = h_v[i-1];
      h_s[i] = h_s[i-1];
      h_t[i] = h_t[i-1];
    end
    h_v[0] = v;
    h_s[0] = ref_round(st, k);
    h_t[0] = tag;
    in_valid = v;
    in_state = st;
    in_key = k;
  endtask

  task automatic drain(input string tag);
    for (int i = 0; i < 3; i++) step(1'b0, 64'h0, 48'h0, tag);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    in_valid = 1'b1;
    in_state = 64'h0123456789ABCDEF;
    repeat (3) @(negedge clk);
    n_chk++;
    if (out_valid !== 1'b0) fail("R2", "out_valid in reset", 64'(out_valid), 64'h0);
    rst = 1'b0;
    in_valid = 1'b0;
    clear_hist();
  endtask

  task automatic t_reset_state();
    do_reset();
    drain("R2");
  endtask

  task automatic t_zero_block();
    // Zero state and key: every table reads entry 0 (R6), result checked (R7, R8)
    step(1'b1, 64'h0, 48'h0, "R6");
    drain("R6");
    // Left half alone changes only the new right half
    step(1'b1, 64'hFFFFFFFF_00000000, 48'h0, "R8");
    step(1'b1, 64'hA5A5A5A5_00000000, 48'h0, "R8");
    drain("R8");
  endtask

  task automatic t_expand_bits();
    // Single-bit right halves hit the shared and wrapped expansion bits
    for (int b = 0; b < 32; b++) step(1'b1, {32'h5A5A0F0F, 32'h1 << b}, 48'h0, "R4");
    drain("R4");
  endtask

  task automatic t_key_mix();
    step(1'b1, 64'h01234567_89ABCDEF, 48'h0, "R5");
    step(1'b1, 64'h01234567_89ABCDEF, 48'hFFFFFFFFFFFF, "R5");
    step(1'b1, 64'h01234567_89ABCDEF, 48'hA5A5A5A5A5A5, "R5");
    for (int b = 0; b < 48; b += 5) step(1'b1, 64'hDEADBEEF_00000000, 48'h1 << b, "R5");
    drain("R5");
  endtask

  task automatic t_table_sweep();
    // Zero right half: subkey is the table input; every box sees value v
    for (int v = 0; v < 64; v++) step(1'b1, 64'h0F1E2D3C_00000000, {8{6'(v)}}, "R6");
    drain("R6");
  endtask

  task automatic t_stream();
    logic [63:0] seed;
    seed = 64'h9E3779B97F4A7C15;
    for (int i = 0; i < 200; i++) begin
      seed ^= seed << 13;
      seed ^= seed >> 7;
      seed ^= seed << 17;
      step(1'b1, seed, seed[47:0] ^ {seed[15:0], seed[63:32]}, "R9");
    end
    drain("R9");
  endtask

  task automatic t_gaps();
    // Data and key toggle while in_valid is low
    for (int i = 0; i < 30; i++) begin
      if (i % 3 == 0) step(1'b1, {32'(i * 7919), 32'(i * 104729)}, 48'(i * 31337), "R10");
      else            step(1'b0, {64{i[0]}}, {48{i[1]}}, "R10");
    end
    drain("R10");
  endtask

  task automatic t_mid_reset();
    step(1'b1, 64'h11112222_33334444, 48'h123456789ABC, "R2");
    step(1'b1, 64'h55556666_77778888, 48'hCBA987654321, "R2");
    do_reset();
    drain("R2");
    step(1'b1, 64'hCAFEF00D_BAADC0DE, 48'h0F0F0F0F0F0F, "R3");
    drain("R3");
  endtask

  initial begin
    clear_hist();
    repeat (3) @(posedge clk);
    t_reset_state();
    t_zero_block();
    t_expand_bits();
    t_key_mix();
    t_table_sweep();
    t_stream();
    t_gaps();
    t_mid_reset();
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    #1000000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule